// File: doc/BRIEF.md
# Read-Unlocked Aliased Configuration Register

This block sits on the host side of a bus-attached peripheral. Two registers share one page-0 offset, 0x0A. A host read of 0x0A returns the configuration byte and arms a one-shot unlock. The next host write to 0x0A then lands in the configuration byte. A write to 0x0A that has no armed unlock goes instead to an 8-bit remote byte-count low register, which drives its own output pin. An access on any other page never reaches either register.

The configuration byte drives three things. Its base code places a 32-byte I/O window that the block matches against incoming host I/O addresses. Its interrupt code routes the single internal interrupt request onto exactly one of eight IRQ lines. Its top bit is a fast-read flag. Downstream remote-DMA read logic uses that flag to start fetching the next port word before the current read strobe ends.

The unlock is a two-state machine.
- **UNL_LOCKED** is the reset state. In this state a write to 0x0A goes to the byte-count register.
- **UNL_ARMED** is the state after a read of 0x0A. In this state a write to 0x0A goes to the configuration byte.

The machine has five transitions:
- **T_ARM** (UNL_LOCKED to UNL_ARMED): a read of 0x0A on page 0.
- **T_REARM** (UNL_ARMED to UNL_ARMED): another read of 0x0A.
- **T_CONSUME** (UNL_ARMED to UNL_LOCKED): the write to 0x0A that the unlock enables.
- **T_CANCEL** (UNL_ARMED to UNL_LOCKED): any other read or write.
- **T_HOLD** (either state to itself): a cycle with no access.

Top module: `cfg_alias_regs`

## Requirements
- R1: After reset the configuration byte is 0x00 and the byte-count output is 0x00. The state is UNL_LOCKED, so the base is 0x300, IRQ line 0 is selected and fast_read is low.
- R2: A read strobe with page 0 and offset 0x0A presents the configuration byte on acc_rdata in the same cycle. Any other read, and any cycle without a read, presents 0x00. The byte layout is: bit 7 is fast read, bits 6:4 are the interrupt code, bits 3:0 are the base code.
- R3: A write to 0x0A while UNL_ARMED loads the configuration byte, takes effect on the next clock edge, and leaves the byte-count output unchanged. Idle cycles between the read and the write do not cancel the unlock.
- R4: A write to 0x0A while UNL_LOCKED loads the byte-count output and leaves the configuration byte unchanged.
- R5: One read unlocks exactly one write. A second write to 0x0A after the enabled one goes to the byte-count register. Repeated reads of 0x0A keep the block armed.
- R6: Any write, or any read other than page 0 offset 0x0A, returns the block to UNL_LOCKED. This includes accesses on other pages and other offsets. Read and write strobes are never high together.
- R7: The base code selects the I/O base. Codes 0 to 7 give 0x300 + 0x20·code. Codes 8 to 15 give 0x200 + 0x20·(code−8). io_sel is high exactly when io_addr lies in [base, base+0x1F].
- R8: While int_req is high, exactly one bit of irq_out is high: bit k for interrupt code k. The bits correspond in order to IRQ3, IRQ4, IRQ5, IRQ9, IRQ10, IRQ11, IRQ12 and IRQ15.
- R9: While int_req is low, irq_out is all zero.
- R10: fast_read equals bit 7 of the configuration byte.
- R11: A write or read at offset 0x0A on a page other than 0 changes neither register and reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_rd | input | 1 | Host register read strobe, one cycle per access |
| acc_wr | input | 1 | Host register write strobe, one cycle per access |
| acc_page | input | 2 | Register page of the access |
| acc_off | input | 4 | Register offset of the access |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, combinational |
| io_addr | input | 10 | Host I/O address to be matched |
| io_sel | output | 1 | High when io_addr is inside the configured window |
| io_base | output | 10 | Currently configured I/O base |
| int_req | input | 1 | Internal interrupt condition |
| irq_out | output | 8 | Steered interrupt lines (IRQ3,4,5,9,10,11,12,15) |
| fast_read | output | 1 | Fast-read enable flag |
| rbc_lo | output | 8 | Remote byte-count low register |

## Verification
The assertions take for granted that acc_rd and acc_wr are single-cycle strobes that are never high together, and one property checks this. They also take for granted that register inputs are stable across each clock edge. The stimulus drives every access on the falling edge, holds it for one full cycle and never issues read and write together. The stimulus mixes armed writes, locked writes, cancelling accesses on other offsets and pages, and idle gaps, and it sweeps every base and interrupt code.

// File: rtl/cfg_alias_pkg.sv
package cfg_alias_pkg;

    typedef enum logic [0:0] {
        UNL_LOCKED = 1'b0,
        UNL_ARMED  = 1'b1
    } unlock_state_e;

    // Field layout of the configuration byte (bit 7 down to bit 0)
    typedef struct packed {
        logic       fast_rd;
        logic [2:0] irq_code;
        logic [3:0] base_code;
    } cfg_word_t;

endpackage

// File: rtl/alias_unlock_fsm.sv
module alias_unlock_fsm
    import cfg_alias_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acc_rd,
    input  logic acc_wr,
    input  logic alias_hit,
    output logic cfg_we,
    output logic rbc_we,
    output logic armed
);

    unlock_state_e state_q, state_d;

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UNL_LOCKED: begin
                if (acc_rd && alias_hit)
                    state_d = UNL_ARMED;           // T_ARM
            end
            UNL_ARMED: begin
                if (acc_rd && alias_hit)
                    state_d = UNL_ARMED;           // T_REARM
                else if (acc_wr && alias_hit)
                    state_d = UNL_LOCKED;          // T_CONSUME
                else if (acc_rd || acc_wr)
                    state_d = UNL_LOCKED;          // T_CANCEL
            end
            default: state_d = UNL_LOCKED;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= UNL_LOCKED;
        else
            state_q <= state_d;
    end

    // Output process
    always_comb begin
        cfg_we = 1'b0;
        rbc_we = 1'b0;
        armed  = 1'b0;
        unique case (state_q)
            UNL_LOCKED: rbc_we = acc_wr && alias_hit;
            UNL_ARMED: begin
                armed  = 1'b1;
                cfg_we = acc_wr && alias_hit;
            end
            default: ;
        endcase
    end

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_rd && acc_wr)); // R6
    AST_ARM_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(acc_rd && alias_hit)); // R5
    AST_ONE_WRITE_PER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !cfg_we); // R5
    AST_CANCEL_ON_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (acc_wr || (acc_rd && !alias_hit))) |=> !armed); // R6

endmodule

// File: rtl/io_window_decode.sv
module io_window_decode #(
    parameter int CODE_W = 4,
    parameter int WIN_W  = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CODE_W-1:0]           base_code,
    input  logic [CODE_W+WIN_W:0]       io_addr,
    output logic                        io_sel,
    output logic [CODE_W+WIN_W:0]       io_base
);

    localparam int ADDR_W = CODE_W + WIN_W + 1;
    localparam int HI_W   = ADDR_W - WIN_W;

    logic [HI_W-1:0] base_hi;

    // Upper code bit flips the base between the 0x3xx and 0x2xx half
    assign base_hi = {1'b1, ~base_code[CODE_W-1], base_code[CODE_W-2:0]};
    assign io_base = {base_hi, {WIN_W{1'b0}}};
    assign io_sel  = (io_addr[ADDR_W-1:WIN_W] == base_hi);

    AST_SEL_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        io_sel |-> (({1'b0, io_addr} >= {1'b0, io_base}) &&
                    ({1'b0, io_addr} < ({1'b0, io_base} + (ADDR_W+1)'(1 << WIN_W))))); // R7
    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == io_base) |-> io_sel); // R7

endmodule

// File: rtl/irq_steer.sv
module irq_steer #(
    parameter int N_IRQ = 8,
    localparam int SEL_W = $clog2(N_IRQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] irq_code,
    input  logic             int_req,
    output logic [N_IRQ-1:0] irq_out
);

    for (genvar k = 0; k < N_IRQ; k++) begin : g_line
        assign irq_out[k] = int_req && (irq_code == SEL_W'(k));
    end

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> ($countones(irq_out) == 1)); // R8
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !int_req |-> (irq_out == '0)); // R9

endmodule

// File: rtl/cfg_alias_regs.sv
module cfg_alias_regs
    import cfg_alias_pkg::*;
#(
    parameter int          DATA_W    = 8,
    parameter int          PAGE_W    = 2,
    parameter int          OFF_W     = 4,
    parameter logic [3:0]  ALIAS_OFF = 4'hA,
    parameter int          CODE_W    = 4,
    parameter int          WIN_W     = 5,
    parameter int          N_IRQ     = 8,
    localparam int         ADDR_W    = CODE_W + WIN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [PAGE_W-1:0] acc_page,
    input  logic [OFF_W-1:0]  acc_off,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              io_sel,
    output logic [ADDR_W-1:0] io_base,
    input  logic              int_req,
    output logic [N_IRQ-1:0]  irq_out,
    output logic              fast_read,
    output logic [DATA_W-1:0] rbc_lo
);

    logic      alias_hit;
    logic      cfg_we, rbc_we, armed;
    cfg_word_t cfg_q;
    logic [DATA_W-1:0] rbc_q;

    assign alias_hit = (acc_page == '0) && (acc_off == OFF_W'(ALIAS_OFF));

    alias_unlock_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_rd    (acc_rd),
        .acc_wr    (acc_wr),
        .alias_hit (alias_hit),
        .cfg_we    (cfg_we),
        .rbc_we    (rbc_we),
        .armed     (armed)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            rbc_q <= '0;
        end else begin
            if (cfg_we) cfg_q <= cfg_word_t'(acc_wdata);
            if (rbc_we) rbc_q <= acc_wdata;
        end
    end

    assign acc_rdata = (acc_rd && alias_hit) ? DATA_W'(cfg_q) : '0;
    assign rbc_lo    = rbc_q;
    assign fast_read = cfg_q.fast_rd;

    io_window_decode #(.CODE_W(CODE_W), .WIN_W(WIN_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_code (cfg_q.base_code),
        .io_addr   (io_addr),
        .io_sel    (io_sel),
        .io_base   (io_base)
    );

    irq_steer #(.N_IRQ(N_IRQ)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_code (cfg_q.irq_code),
        .int_req  (int_req),
        .irq_out  (irq_out)
    );

    AST_LOCKED_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && alias_hit && !armed) |=> $stable(cfg_q)); // R4
    AST_ARMED_KEEPS_RBC: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> $stable(rbc_q)); // R3
    AST_FOREIGN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_wr || acc_rd) && (acc_page != '0)) |=> ($stable(cfg_q) && $stable(rbc_q))); // R11

endmodule

// File: tb/tb_cfg_alias_regs.sv
module tb_cfg_alias_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_rd = 1'b0, acc_wr = 1'b0;
    logic [1:0] acc_page = '0;
    logic [3:0] acc_off = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic [9:0] io_addr = '0;
    logic       io_sel;
    logic [9:0] io_base;
    logic       int_req = 1'b0;
    logic [7:0] irq_out;
    logic       fast_read;
    logic [7:0] rbc_lo;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string phase = "R1";

    // Behavioural reference state
    int m_cfg = 0;
    int m_rbc = 0;
    bit m_unlock = 0;
    int acc_log[$];

    always #2 clk = ~clk;

    cfg_alias_regs dut (
        .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .acc_page(acc_page), .acc_off(acc_off), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .io_addr(io_addr), .io_sel(io_sel),
        .io_base(io_base), .int_req(int_req), .irq_out(irq_out),
        .fast_read(fast_read), .rbc_lo(rbc_lo)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 0; m_rbc = 0; m_unlock = 0;
        end else begin
            bit hit;
            hit = (acc_page == 0) && (acc_off == 10);
            if (acc_rd || acc_wr) acc_log.push_back({acc_wr, acc_page, acc_off});
            if (acc_wr && hit) begin
                if (m_unlock) m_cfg = int'(acc_wdata);
                else          m_rbc = int'(acc_wdata);
            end
            if (acc_rd && hit)          m_unlock = 1;
            else if (acc_rd || acc_wr)  m_unlock = 0;
        end
    end

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
        end
    endtask

    task automatic compare_all();
        int code, base, e_irq, e_rd;
        code = m_cfg % 16;
        base = (code >= 8) ? 512 + 32 * (code - 8) : 768 + 32 * code;
        e_irq = int_req ? (1 << ((m_cfg / 16) % 8)) : 0;
        e_rd = (acc_rd && acc_page == 0 && acc_off == 10) ? m_cfg : 0;
        chk("rdata", int'(acc_rdata), e_rd);
        chk("rbc_lo", int'(rbc_lo), m_rbc);
        chk("io_base", int'(io_base), base);
        chk("io_sel", int'(io_sel), (int'(io_addr) >= base && int'(io_addr) < base + 32) ? 1 : 0);
        chk("irq_out", int'(irq_out), e_irq);
        chk("fast_read", int'(fast_read), (m_cfg >= 128) ? 1 : 0);
    endtask

    // One cycle: drive on falling edge, compare shortly after
    task automatic cyc(bit rd, bit wr, int pg, int off, int wd);
        @(negedge clk);
        acc_rd = rd; acc_wr = wr;
        acc_page = 2'(pg); acc_off = 4'(off); acc_wdata = 8'(wd);
        #1 compare_all();
    endtask

    task automatic idle(); cyc(0, 0, 0, 0, 0); endtask
    task automatic rd_alias(); cyc(1, 0, 0, 10, 0); endtask
    task automatic wr_alias(int v); cyc(0, 1, 0, 10, v); endtask

    task automatic set_cfg(int v);
        rd_alias(); wr_alias(v); idle();
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state with interrupt active at base address
        phase = "R1";
        int_req = 1'b1; io_addr = 10'h300;
        repeat (3) idle();
        @(negedge clk); rst_n = 1'b1;
        idle(); idle();

        // R2 / R3: read shows config, armed write loads it
        phase = "R2"; rd_alias(); idle();
        phase = "R3"; set_cfg(8'h95); rd_alias(); idle();
        rd_alias(); idle(); idle(); wr_alias(8'h21); idle();

        // R4: write without unlock goes to byte count
        phase = "R4"; wr_alias(8'h3C); idle(); wr_alias(8'hC3); idle();

        // R5: one write per read, re-arm by repeated reads
        phase = "R5"; rd_alias(); wr_alias(8'h12); wr_alias(8'h77); idle();
        rd_alias(); rd_alias(); wr_alias(8'h4A); idle();

        // R6: other accesses cancel the unlock
        phase = "R6";
        rd_alias(); cyc(0, 1, 0, 3, 8'h55); wr_alias(8'h66); idle();
        rd_alias(); cyc(1, 0, 0, 5, 0); wr_alias(8'h67); idle();
        rd_alias(); cyc(1, 0, 1, 10, 0); wr_alias(8'h68); idle();

        // R11: foreign page at alias offset touches nothing
        phase = "R11";
        cyc(0, 1, 1, 10, 8'hEE); idle(); cyc(1, 0, 2, 10, 0); idle();
        rd_alias(); cyc(0, 1, 3, 10, 8'hDD); idle();

        // R7: every base code with window edges
        phase = "R7";
        for (int c = 0; c < 16; c++) begin
            int b;
            b = (c >= 8) ? 512 + 32 * (c - 8) : 768 + 32 * c;
            set_cfg(c);
            io_addr = 10'(b - 1);  idle();
            io_addr = 10'(b);      idle();
            io_addr = 10'(b + 31); idle();
            io_addr = 10'(b + 32); idle();
        end

        // R8 / R9: every interrupt code, request on and off
        for (int q = 0; q < 8; q++) begin
            phase = "R8"; int_req = 1'b1; set_cfg(q * 16 + 5);
            phase = "R9"; int_req = 1'b0; idle();
        end

        // R10: fast-read flag follows bit 7
        phase = "R10"; set_cfg(8'h80); set_cfg(8'h7F); set_cfg(8'hFF);
        idle();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule